// File: doc/BRIEF.md
# Folded Constant-Geometry Radix-2 FFT

This block computes an N-point discrete Fourier transform of complex fixed-point samples. N is a power of two and is 8 by default. The computation is split into log2(N) radix-2 passes. Every pass has the same wiring: the vector is perfect-shuffled, the upper half of each pair is rotated by a twiddle factor, and a column of N/2 two-point butterflies combines the pairs. Because every pass has the same wiring, only one pass of hardware is built. A bypass multiplexer feeds that pass with the external vector on the first pass and with its own registered result on each later pass.

The user presents a whole vector in parallel and pulses `start`. The result appears log2(N) clock edges later, together with a one-cycle `done` pulse. It stays in the output register until the next accepted start. Each butterfly halves its outputs, so the result is the transform divided by N. The output is left in bit-reversed order: position p holds frequency bin bitrev(p).

Top module: `cgfft_fold`

## Requirements
- R1: After synchronous reset, `busy` and `done` are low and every output element is zero.
- R2: A `start` sampled while `busy` is low is accepted. For N > 2, `busy` is high in the cycles following the accepting edge and the next log2(N)-2 edges, and it drops at the edge that raises `done`. `done` rises log2(N)-1 edges after the accepting edge.
- R3: `done` is high for exactly one cycle per accepted start, and it is never high together with `busy`.
- R4: Sample i occupies bits [i*DW +: DW] of each input bus, and result position p occupies the same bits of each output bus. All values are two's complement. Output position p equals X[bitrev(p)]/N within ±4 LSB, where X[f] = Σ x[n]·e^(-2πi·n·f/N) and bitrev reverses log2(N) bits. This holds for impulse, constant and random vectors.
- R5: A complex tone x[n] = A·e^(+2πi·f·n/N) produces about A at position bitrev(f) and about zero at every other position.
- R6: A `start` sampled while `busy` is high is ignored. The `done` timing and the result stay those of the vector that was already accepted.
- R7: While `busy` is low and no start is accepted, the outputs hold their value, whatever the inputs do.
- R8: Full-scale inputs (±32767) give the correctly scaled result without wrap-around. The twiddle products saturate to the data width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Pulse that launches a transform when idle |
| in_re | input | N_PTS*DW | Real parts of the input samples |
| in_im | input | N_PTS*DW | Imaginary parts of the input samples |
| out_re | output | N_PTS*DW | Real parts of the result, bit-reversed order |
| out_im | output | N_PTS*DW | Imaginary parts of the result, bit-reversed order |
| done | output | 1 | One-cycle pulse when the result is valid |
| busy | output | 1 | High while later passes remain |

## Verification
The bench builds the block with N_PTS = 8, DW = 16 and TW_W = 16. These values give three passes, so every twiddle class is used: the all-ones first pass, the ±1/±i second pass and the 45-degree third pass. The three passes also make the busy window long enough for a second start to land inside it. Sixteen-bit data lets full-scale values exercise the saturation of the rotated products. Eight points keep the bench's own direct DFT cheap enough to run on every vector.

// File: rtl/cgfft_pkg.sv
package cgfft_pkg;

   localparam real PI = 3.14159265358979323846;

   // Reverse the lowest 'bits' bits of v
   function automatic int bitrev(input int v, input int bits);
      int r;
      r = 0;
      for (int b = 0; b < bits; b++) begin
         r = (r << 1) | ((v >> b) & 1);
      end
      return r;
   endfunction

   // Twiddle exponent for butterfly k in pass s (first pass uses exponent 0)
   function automatic int tw_exp(input int s, input int k, input int log2n);
      int low;
      if (s >= log2n) return 0;
      low = k & ((1 << s) - 1);
      return bitrev(low, s) << (log2n - 1 - s);
   endfunction

   // Rounded fixed-point cosine (want_sin=0) or negated sine (want_sin=1)
   function automatic int tw_q(input int e, input int n, input int frac, input bit want_sin);
      real ang;
      real v;
      real scale;
      ang   = 2.0 * PI * e / n;
      v     = want_sin ? -$sin(ang) : $cos(ang);
      scale = 1.0;
      for (int i = 0; i < frac; i++) scale = scale * 2.0;
      v = v * scale;
      return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
   endfunction

endpackage

// File: rtl/cgfft_twiddle_sel.sv
module cgfft_twiddle_sel #(
   parameter int N_PTS = 8,
   parameter int TW_W  = 16,
   parameter int SW    = 2
) (
   input  logic [SW-1:0]               stage,
   output logic [(N_PTS/2)*TW_W-1:0]   w_re,
   output logic [(N_PTS/2)*TW_W-1:0]   w_im
);
   localparam int HALF  = N_PTS / 2;
   localparam int LOG2N = $clog2(N_PTS);
   localparam int FRAC  = TW_W - 2;
   localparam int TABN  = 1 << SW;

   for (genvar k = 0; k < HALF; k++) begin : g_bfly
      logic [TW_W-1:0] re_t [TABN];
      logic [TW_W-1:0] im_t [TABN];
      for (genvar s = 0; s < TABN; s++) begin : g_stage
         localparam int EXP = cgfft_pkg::tw_exp(s, k, LOG2N);
         localparam int CR  = cgfft_pkg::tw_q(EXP, N_PTS, FRAC, 1'b0);
         localparam int CI  = cgfft_pkg::tw_q(EXP, N_PTS, FRAC, 1'b1);
         assign re_t[s] = TW_W'(CR);
         assign im_t[s] = TW_W'(CI);
      end
      assign w_re[k*TW_W +: TW_W] = re_t[stage];
      assign w_im[k*TW_W +: TW_W] = im_t[stage];
   end
endmodule

// File: rtl/cgfft_cmul.sv
module cgfft_cmul #(
   parameter int DW   = 16,
   parameter int TW_W = 16
) (
   input  logic signed [DW-1:0]   b_re,
   input  logic signed [DW-1:0]   b_im,
   input  logic signed [TW_W-1:0] w_re,
   input  logic signed [TW_W-1:0] w_im,
   output logic signed [DW-1:0]   p_re,
   output logic signed [DW-1:0]   p_im
);
   localparam int PW   = DW + TW_W;
   localparam int FRAC = TW_W - 2;
   localparam logic signed [PW:0] RND  = {{(PW-FRAC+1){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};
   localparam logic signed [PW:0] MAXV = {{(PW-DW+2){1'b0}}, {(DW-1){1'b1}}};
   localparam logic signed [PW:0] MINV = {{(PW-DW+2){1'b1}}, {(DW-1){1'b0}}};

   logic signed [PW-1:0] rr, ii, ri, ir;
   logic signed [PW:0]   sum_re, sum_im, sh_re, sh_im;

   assign rr = PW'(b_re) * PW'(w_re);
   assign ii = PW'(b_im) * PW'(w_im);
   assign ri = PW'(b_re) * PW'(w_im);
   assign ir = PW'(b_im) * PW'(w_re);

   assign sum_re = (PW+1)'(rr) - (PW+1)'(ii) + RND;
   assign sum_im = (PW+1)'(ri) + (PW+1)'(ir) + RND;
   assign sh_re  = sum_re >>> FRAC;
   assign sh_im  = sum_im >>> FRAC;

   always_comb begin
      if (sh_re > MAXV)      p_re = {1'b0, {(DW-1){1'b1}}};
      else if (sh_re < MINV) p_re = {1'b1, {(DW-1){1'b0}}};
      else                   p_re = DW'(sh_re);
      if (sh_im > MAXV)      p_im = {1'b0, {(DW-1){1'b1}}};
      else if (sh_im < MINV) p_im = {1'b1, {(DW-1){1'b0}}};
      else                   p_im = DW'(sh_im);
   end
endmodule

// File: rtl/cgfft_bfly.sv
module cgfft_bfly #(
   parameter int DW = 16
) (
   input  logic signed [DW-1:0] a_re,
   input  logic signed [DW-1:0] a_im,
   input  logic signed [DW-1:0] b_re,
   input  logic signed [DW-1:0] b_im,
   output logic signed [DW-1:0] s_re,
   output logic signed [DW-1:0] s_im,
   output logic signed [DW-1:0] d_re,
   output logic signed [DW-1:0] d_im
);
   logic signed [DW:0] ps_re, ps_im, pd_re, pd_im;

   assign ps_re = (DW+1)'(a_re) + (DW+1)'(b_re);
   assign ps_im = (DW+1)'(a_im) + (DW+1)'(b_im);
   assign pd_re = (DW+1)'(a_re) - (DW+1)'(b_re);
   assign pd_im = (DW+1)'(a_im) - (DW+1)'(b_im);

   // halve every output so the pass cannot grow past the data width
   assign s_re = DW'(ps_re >>> 1);
   assign s_im = DW'(ps_im >>> 1);
   assign d_re = DW'(pd_re >>> 1);
   assign d_im = DW'(pd_im >>> 1);
endmodule

// File: rtl/cgfft_fold.sv
module cgfft_fold #(
   parameter int N_PTS = 8,
   parameter int DW    = 16,
   parameter int TW_W  = 16
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                start,
   input  logic [N_PTS*DW-1:0] in_re,
   input  logic [N_PTS*DW-1:0] in_im,
   output logic [N_PTS*DW-1:0] out_re,
   output logic [N_PTS*DW-1:0] out_im,
   output logic                done,
   output logic                busy
);
   localparam int LOG2N = $clog2(N_PTS);
   localparam int HALF  = N_PTS / 2;
   localparam int SW    = (LOG2N > 1) ? $clog2(LOG2N) : 1;
   localparam int VW    = N_PTS * DW;

   if (N_PTS < 2 || (1 << LOG2N) != N_PTS) begin : g_bad_n
      $error("cgfft_fold: N_PTS must be a power of two of at least 2");
   end
   if (DW < 4 || TW_W < 4) begin : g_bad_w
      $error("cgfft_fold: DW and TW_W must be at least 4");
   end

   logic [SW-1:0]        cnt_q, cur_stage;
   logic                 busy_q, done_q, fire, last;
   logic [VW-1:0]        data_re_q, data_im_q;
   logic [VW-1:0]        src_re, src_im, shf_re, shf_im, nxt_re, nxt_im;
   logic [HALF*TW_W-1:0] tw_re, tw_im;

   // bypass: fresh vector on the first pass, fed-back result afterwards
   assign cur_stage = busy_q ? cnt_q : '0;
   assign src_re    = busy_q ? data_re_q : in_re;
   assign src_im    = busy_q ? data_im_q : in_im;
   assign fire      = busy_q | start;
   assign last      = (cur_stage == SW'(LOG2N - 1));

   // perfect shuffle as pure wiring: i -> 2i mod (N-1), last element fixed
   for (genvar i = 0; i < N_PTS; i++) begin : g_shuffle
      localparam int DST = (i == N_PTS - 1) ? i : (2 * i) % (N_PTS - 1);
      assign shf_re[DST*DW +: DW] = src_re[i*DW +: DW];
      assign shf_im[DST*DW +: DW] = src_im[i*DW +: DW];
   end

   cgfft_twiddle_sel #(.N_PTS(N_PTS), .TW_W(TW_W), .SW(SW)) u_tw (
      .stage (cur_stage),
      .w_re  (tw_re),
      .w_im  (tw_im)
   );

   for (genvar k = 0; k < HALF; k++) begin : g_col
      logic signed [DW-1:0] m_re, m_im;
      logic signed [DW-1:0] s_re, s_im, d_re, d_im;

      cgfft_cmul #(.DW(DW), .TW_W(TW_W)) u_mul (
         .b_re (shf_re[(2*k+1)*DW +: DW]),
         .b_im (shf_im[(2*k+1)*DW +: DW]),
         .w_re (tw_re[k*TW_W +: TW_W]),
         .w_im (tw_im[k*TW_W +: TW_W]),
         .p_re (m_re),
         .p_im (m_im)
      );

      cgfft_bfly #(.DW(DW)) u_bf (
         .a_re (shf_re[(2*k)*DW +: DW]),
         .a_im (shf_im[(2*k)*DW +: DW]),
         .b_re (m_re),
         .b_im (m_im),
         .s_re (s_re),
         .s_im (s_im),
         .d_re (d_re),
         .d_im (d_im)
      );

      assign nxt_re[(2*k)*DW +: DW]   = s_re;
      assign nxt_im[(2*k)*DW +: DW]   = s_im;
      assign nxt_re[(2*k+1)*DW +: DW] = d_re;
      assign nxt_im[(2*k+1)*DW +: DW] = d_im;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q    <= 1'b0;
         done_q    <= 1'b0;
         cnt_q     <= '0;
         data_re_q <= '0;
         data_im_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (fire) begin
            data_re_q <= nxt_re;
            data_im_q <= nxt_im;
            if (last) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
               cnt_q  <= '0;
            end else begin
               busy_q <= 1'b1;
               cnt_q  <= cur_stage + SW'(1);
            end
         end
      end
   end

   assign out_re = data_re_q;
   assign out_im = data_im_q;
   assign done   = done_q;
   assign busy   = busy_q;
endmodule

// File: rtl/cgfft_fold_chk.sv
module cgfft_fold_chk #(
   parameter int N_PTS = 8,
   parameter int DW    = 16
) (
   input logic                clk,
   input logic                rst,
   input logic                start,
   input logic [N_PTS*DW-1:0] out_re,
   input logic [N_PTS*DW-1:0] out_im,
   input logic                done,
   input logic                busy
);
   localparam int LOG2N = $clog2(N_PTS);

   int   left_q;
   logic exp_done_q;

   // independent pass counter for the latency window
   always_ff @(posedge clk) begin
      if (rst) begin
         left_q     <= 0;
         exp_done_q <= 1'b0;
      end else if (start && !busy) begin
         left_q     <= LOG2N - 1;
         exp_done_q <= (LOG2N == 1);
      end else begin
         exp_done_q <= (left_q == 1);
         if (left_q != 0) left_q <= left_q - 1;
      end
   end

   assert_no_overlap_R3: assert property (@(posedge clk) disable iff (rst)
      !(busy && done));

   assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
      (done && (LOG2N > 1)) |=> !done);

   assert_accept_busy_R2: assert property (@(posedge clk) disable iff (rst)
      (start && !busy && (LOG2N > 1)) |=> busy);

   // R2 and R6: done only at the end of the accepted run's window
   assert_done_window_R6: assert property (@(posedge clk) disable iff (rst)
      done == exp_done_q);

   assert_busy_window_R2: assert property (@(posedge clk) disable iff (rst)
      busy == (left_q != 0));

   assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
      (!busy && !start) |=> ($stable(out_re) && $stable(out_im)));
endmodule

bind cgfft_fold cgfft_fold_chk #(.N_PTS(N_PTS), .DW(DW)) u_chk (
   .clk    (clk),
   .rst    (rst),
   .start  (start),
   .out_re (out_re),
   .out_im (out_im),
   .done   (done),
   .busy   (busy)
);

// File: tb/cgfft_fold_bench.sv
`timescale 1ns/1ps
module cgfft_fold_bench;
   localparam int N     = 8;
   localparam int DW    = 16;
   localparam int LOG2N = 3;
   localparam real TOL  = 4.0;
   localparam real PI   = 3.14159265358979323846;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          start = 1'b0;
   logic [N*DW-1:0] in_re = '0, in_im = '0;
   logic [N*DW-1:0] out_re, out_im;
   logic          done, busy;

   int  checks = 0, errors = 0;
   int  xr [N], xi [N];
   real er [N], ei [N];
   bit  m_busy = 0, m_done = 0, m_have = 0;
   int  m_left = 0;
   string cur_req = "R4";

   always #4 clk = ~clk;

   cgfft_fold #(.N_PTS(N), .DW(DW), .TW_W(16)) u_cgfft_fold (
      .clk(clk), .rst(rst), .start(start),
      .in_re(in_re), .in_im(in_im),
      .out_re(out_re), .out_im(out_im),
      .done(done), .busy(busy)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   function automatic int brev(input int v);
      int r = 0;
      for (int b = 0; b < LOG2N; b++) r = (r << 1) | ((v >> b) & 1);
      return r;
   endfunction

   function automatic int rnd(input real v);
      return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
   endfunction

   task automatic drive_vec();
      for (int i = 0; i < N; i++) begin
         in_re[i*DW +: DW] = xr[i][DW-1:0];
         in_im[i*DW +: DW] = xi[i][DW-1:0];
      end
   endtask

   // direct DFT / N, placed at bit-reversed positions
   task automatic capture_ref();
      for (int p = 0; p < N; p++) begin
         int  f = brev(p);
         real sr = 0.0, si = 0.0;
         for (int n = 0; n < N; n++) begin
            real th = 2.0 * PI * n * f / N;
            sr += xr[n] * $cos(th) + xi[n] * $sin(th);
            si += xi[n] * $cos(th) - xr[n] * $sin(th);
         end
         er[p] = sr / N;
         ei[p] = si / N;
      end
   endtask

   task automatic cmp_outputs(input string req);
      for (int p = 0; p < N; p++) begin
         int ar = int'($signed(out_re[p*DW +: DW]));
         int ai = int'($signed(out_im[p*DW +: DW]));
         real dr = ar - er[p];
         real di = ai - ei[p];
         chk(dr <= TOL && dr >= -TOL, req, $sformatf("out_re[%0d]", p), ar, rnd(er[p]));
         chk(di <= TOL && di >= -TOL, req, $sformatf("out_im[%0d]", p), ai, rnd(ei[p]));
      end
   endtask

   // one clock: update the cycle model at the edge, compare at the falling edge
   task automatic step();
      @(posedge clk);
      m_done = 0;
      if (rst) begin
         m_busy = 0; m_left = 0; m_have = 0;
      end else if (m_busy) begin
         m_left--;
         if (m_left == 0) begin
            m_busy = 0; m_done = 1; m_have = 1;
         end
      end else if (start) begin
         capture_ref();
         m_busy = 1; m_left = LOG2N - 1;
      end
      @(negedge clk);
      if (!rst) begin
         chk(busy == m_busy, "R2", "busy", int'(busy), int'(m_busy));
         chk(done == m_done, "R3", "done", int'(done), int'(m_done));
         if (!m_have && !m_busy) begin
            for (int p = 0; p < N; p++) begin
               chk(out_re[p*DW +: DW] == '0 && out_im[p*DW +: DW] == '0, "R1",
                   $sformatf("reset out[%0d]", p), int'($signed(out_re[p*DW +: DW])), 0);
            end
         end else if (m_done) begin
            cmp_outputs(cur_req);
         end else if (!m_busy) begin
            cmp_outputs("R7");
         end
      end
   endtask

   task automatic run(input string req);
      cur_req = req;
      drive_vec();
      start = 1'b1;
      step();
      start = 1'b0;
      repeat (LOG2N + 1) step();
   endtask

   task automatic clear_vec();
      for (int i = 0; i < N; i++) begin xr[i] = 0; xi[i] = 0; end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      clear_vec();
      drive_vec();
      repeat (3) step();
      rst = 1'b0;
      repeat (2) step();            // R1: reset state observed by step()
      chk(busy == 1'b0 && done == 1'b0, "R1", "flags after reset",
          int'({busy, done}), 0);

      // R4: impulse at index 0
      clear_vec(); xr[0] = 8000;
      run("R4");
      // R4: complex impulse at index 3
      clear_vec(); xr[3] = 4000; xi[3] = -6000;
      run("R4");
      // R4: constant vector
      for (int i = 0; i < N; i++) begin xr[i] = 5000; xi[i] = -3000; end
      run("R4");
      // R5: tone at bin 3 lands at position bitrev(3)
      for (int n = 0; n < N; n++) begin
         xr[n] = rnd(10000.0 * $cos(2.0 * PI * 3 * n / N));
         xi[n] = rnd(10000.0 * $sin(2.0 * PI * 3 * n / N));
      end
      run("R5");
      chk(int'($signed(out_re[brev(3)*DW +: DW])) > 9990, "R5", "tone peak",
          int'($signed(out_re[brev(3)*DW +: DW])), 10000);
      // R4: random vectors
      for (int t = 0; t < 6; t++) begin
         for (int i = 0; i < N; i++) begin
            xr[i] = int'($urandom_range(24000)) - 12000;
            xi[i] = int'($urandom_range(24000)) - 12000;
         end
         run("R4");
      end

      // R6: second start while busy is ignored
      cur_req = "R6";
      for (int i = 0; i < N; i++) begin xr[i] = 1000 * i; xi[i] = -700 * i; end
      drive_vec();
      start = 1'b1;
      step();
      for (int i = 0; i < N; i++) begin xr[i] = 9000; xi[i] = 9000; end
      drive_vec();
      repeat (LOG2N - 1) step();    // start still high while busy
      start = 1'b0;
      repeat (2) step();

      // R7: idle with changing inputs, no start
      for (int t = 0; t < 5; t++) begin
         for (int i = 0; i < N; i++) xr[i] = int'($urandom_range(20000)) - 10000;
         drive_vec();
         step();
      end

      // R8: full-scale constant and alternating inputs
      for (int i = 0; i < N; i++) begin xr[i] = 32767; xi[i] = 0; end
      run("R8");
      chk(int'($signed(out_re[0 +: DW])) >= 32763, "R8", "full-scale dc",
          int'($signed(out_re[0 +: DW])), 32767);
      for (int i = 0; i < N; i++) begin xr[i] = (i % 2 == 0) ? 32767 : -32767; xi[i] = 0; end
      run("R8");
      chk(int'($signed(out_re[brev(N/2)*DW +: DW])) >= 32763, "R8", "full-scale nyquist",
          int'($signed(out_re[brev(N/2)*DW +: DW])), 32767);
      for (int i = 0; i < N; i++) begin xr[i] = -32767; xi[i] = 32767; end
      run("R8");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule